// File: doc/BRIEF.md
# Double-Buffered Crosspoint Switch Controller

This block is a non-blocking crosspoint router between a bank of single-bit data inputs and a bank of single-bit data outputs. Each output has its own multiplexer and its own enable flag, so any input can feed any number of outputs at once, including all of them. Each output's route is held in a small configuration word. The upper bits of the word name the source input. The lowest bit is a disable flag: 1 means disabled, 0 means enabled.

Configuration is double-buffered. A host writes one output's word at a time into a staging rank. That rank has no effect on the data path. A single commit strobe then copies the whole staging rank into the live rank, which steers the multiplexers, so every output changes in the same cycle. A preset strobe forces both ranks to a known pattern. In that pattern every output selects input 0, and the disable level presented with the strobe decides whether all outputs are enabled (a broadcast of input 0) or all are disabled. A select line gates all three strobes.

All strobes are sampled in one clock domain and act on their low-to-high transition. The data path itself is combinational from the inputs to the outputs. It is never interrupted by staging writes, so an output whose live word does not change keeps passing data through writes and commits.

Top module: `xbar_ctrl`

## Requirements
- R1: After synchronous reset both ranks hold input 0 with the disable flag set, so every output bit and every enable flag reads 0.
- R2: An output whose live word is enabled drives the bit of the input named by the word's upper bits and raises its enable flag. A disabled output drives 0 with its enable flag low. This follows input changes without a clock edge.
- R3: In the first clock cycle in which the stage strobe is seen high after being low, with select high, the staging word addressed by the output address becomes {input address, disable level}. No other staging word and no live word changes.
- R4: In the first clock cycle in which the commit strobe is seen high after being low, with select high, all staging words are copied into the live rank at the same edge. Outputs show the new routes one clock after the rising edge is sampled.
- R5: Live words change only on a commit or a preset. An output whose live word is unchanged keeps following its input across staging writes and commits.
- R6: A preset strobe rising edge with select high and the disable level low sets every word in both ranks to input 0, enabled.
- R7: A preset strobe rising edge with select high and the disable level high sets every word in both ranks to input 0, disabled.
- R8: While select is low, stage, commit and preset strobes have no effect on either rank.
- R9: A strobe held high for several cycles acts once, on its rising edge. Address and data changes during the held level are not captured.
- R10: When stage and commit rise in the same cycle, the commit copies the staging rank with that cycle's write already applied.
- R11: When preset rises in the same cycle as stage and/or commit, the preset pattern wins in both ranks.
- R12: One input may be routed to all outputs at once, and every output then tracks that input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 8 | Data inputs |
| dout | output | 8 | Data outputs, 0 when disabled |
| dout_en | output | 8 | Per-output enable flags |
| in_sel | input | 3 | Source input address for a staging write |
| out_sel | input | 3 | Target output address for a staging write |
| off_req | input | 1 | Disable level: word data bit on staging writes, preset mode choice |
| stage_stb | input | 1 | Staging write strobe (rising edge) |
| commit_stb | input | 1 | Commit strobe (rising edge) |
| preset_stb | input | 1 | Preset strobe (rising edge) |
| sel_en | input | 1 | Select; gates all three strobes |

## Verification
Two pairs of functions can land in the same cycle. In the first, a staging write and a commit collide: the bench raises both strobes at the same sampled edge and expects the outputs to show the word just written. In the second, a preset collides with a write and a commit: the bench raises all three together and then does a separate commit, and expects both ranks to hold the preset pattern. A reference model of both ranks in the bench predicts the outputs for several input patterns after every strobe.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    // Meaning of the lowest bit of a configuration word
    typedef enum logic {
        PATH_ON  = 1'b0,
        PATH_OFF = 1'b1
    } path_mode_e;

    // Single-cycle pulses produced from the strobe inputs
    typedef struct packed {
        logic stage;
        logic commit;
        logic preset;
    } strobe_t;

endpackage

// File: rtl/xbar_edge.sv
module xbar_edge
    import xbar_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sel_en,
    input  logic    stage_lvl,
    input  logic    commit_lvl,
    input  logic    preset_lvl,
    output strobe_t go
);

    typedef struct packed {
        logic stage;
        logic commit;
        logic preset;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.stage  = stage_lvl;
        prev_d.commit = commit_lvl;
        prev_d.preset = preset_lvl;

        go.stage  = sel_en & stage_lvl  & ~prev_q.stage;
        go.commit = sel_en & commit_lvl & ~prev_q.commit;
        go.preset = sel_en & preset_lvl & ~prev_q.preset;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    // R9: a pulse never repeats on the next cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (go != '0) |=> ((go & $past(go)) == '0));

endmodule

// File: rtl/xbar_stage_rank.sv
module xbar_stage_rank
    import xbar_pkg::*;
#(
    parameter int NP = 8,
    parameter int SW = 3,
    parameter int OW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  strobe_t              go,
    input  logic [OW-1:0]        out_sel,
    input  logic [SW-1:0]        in_sel,
    input  logic                 off_req,
    output logic [NP-1:0][SW:0]  stage_q,
    output logic [NP-1:0][SW:0]  stage_nxt
);

    localparam int CW = SW + 1;

    typedef struct packed {
        logic [NP-1:0][SW:0] words;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] preset_word;
    logic [CW-1:0] write_word;

    always_comb begin
        preset_word = {{SW{1'b0}}, off_req};
        write_word  = {in_sel, off_req};
        st_d        = st_q;
        if (go.preset) begin
            for (int w = 0; w < NP; w++) st_d.words[w] = preset_word;
        end else if (go.stage) begin
            st_d.words[out_sel] = write_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NP; w++) st_q.words[w] <= {{SW{1'b0}}, PATH_OFF};
        end else begin
            st_q <= st_d;
        end
    end

    assign stage_q   = st_q.words;
    assign stage_nxt = st_d.words;

    // R3: staging rank holds without a stage or preset pulse
    a_r3_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!go.stage && !go.preset) |=> $stable(stage_q));

endmodule

// File: rtl/xbar_live_rank.sv
module xbar_live_rank
    import xbar_pkg::*;
#(
    parameter int NP = 8,
    parameter int SW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  strobe_t              go,
    input  logic                 off_req,
    input  logic [NP-1:0][SW:0]  stage_nxt,
    output logic [NP-1:0][SW:0]  live_q
);

    typedef struct packed {
        logic [NP-1:0][SW:0] words;
    } lv_t;

    lv_t lv_d, lv_q;

    always_comb begin
        lv_d = lv_q;
        if (go.preset) begin
            for (int w = 0; w < NP; w++) lv_d.words[w] = {{SW{1'b0}}, off_req};
        end else if (go.commit) begin
            lv_d.words = stage_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NP; w++) lv_q.words[w] <= {{SW{1'b0}}, PATH_OFF};
        end else begin
            lv_q <= lv_d;
        end
    end

    assign live_q = lv_q.words;

    // R5: live rank changes only on commit or preset
    a_r5_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!go.commit && !go.preset) |=> $stable(live_q));

endmodule

// File: rtl/xbar_route.sv
module xbar_route
    import xbar_pkg::*;
#(
    parameter int NI = 8,
    parameter int NP = 8,
    parameter int SW = 3
) (
    input  logic [NI-1:0]        din,
    input  logic [NP-1:0][SW:0]  live_q,
    output logic [NP-1:0]        dout,
    output logic [NP-1:0]        dout_en
);

    for (genvar o = 0; o < NP; o++) begin : g_out
        logic [SW-1:0] src;
        logic          on;
        logic          bit_sel;
        assign src = live_q[o][SW:1];
        assign on  = (live_q[o][0] == PATH_ON);
        always_comb begin
            bit_sel = 1'b0;
            for (int i = 0; i < NI; i++) begin
                if (src == SW'(i)) bit_sel = din[i];
            end
        end
        assign dout[o]    = on & bit_sel;
        assign dout_en[o] = on;
    end

endmodule

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
    import xbar_pkg::*;
#(
    parameter int NI = 8,
    parameter int NP = 8,
    localparam int SW = (NI > 1) ? $clog2(NI) : 1,
    localparam int OW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NI-1:0] din,
    output logic [NP-1:0] dout,
    output logic [NP-1:0] dout_en,
    input  logic [SW-1:0] in_sel,
    input  logic [OW-1:0] out_sel,
    input  logic          off_req,
    input  logic          stage_stb,
    input  logic          commit_stb,
    input  logic          preset_stb,
    input  logic          sel_en
);

    strobe_t             go;
    logic [NP-1:0][SW:0] stage_q;
    logic [NP-1:0][SW:0] stage_nxt;
    logic [NP-1:0][SW:0] live_q;

    xbar_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_en     (sel_en),
        .stage_lvl  (stage_stb),
        .commit_lvl (commit_stb),
        .preset_lvl (preset_stb),
        .go         (go)
    );

    xbar_stage_rank #(.NP(NP), .SW(SW), .OW(OW)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .out_sel   (out_sel),
        .in_sel    (in_sel),
        .off_req   (off_req),
        .stage_q   (stage_q),
        .stage_nxt (stage_nxt)
    );

    xbar_live_rank #(.NP(NP), .SW(SW)) u_live (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .off_req   (off_req),
        .stage_nxt (stage_nxt),
        .live_q    (live_q)
    );

    xbar_route #(.NI(NI), .NP(NP), .SW(SW)) u_route (
        .din     (din),
        .live_q  (live_q),
        .dout    (dout),
        .dout_en (dout_en)
    );

    // R2: a disabled output never drives a 1
    a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (dout & ~dout_en) == '0);

    // R4: commit copies the staging rank as of that edge
    a_r4_commit_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (go.commit && !go.preset) |=> (live_q == $past(stage_nxt)));

    // R6: preset with disable low enables every output
    a_r6_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
        (go.preset && !off_req) |=> (dout_en == '1));

    // R7: preset with disable high disables every output
    a_r7_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        (go.preset && off_req) |=> (dout_en == '0));

    // R8: select low leaves both ranks untouched
    a_r8_select_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_en |=> ($stable(live_q) && $stable(stage_q)));

endmodule

// File: tb/xbar_ctrl_test.sv
module xbar_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout, dout_en;
    logic [2:0] in_sel = '0, out_sel = '0;
    logic       off_req = 1'b0;
    logic       stage_stb = 1'b0, commit_stb = 1'b0, preset_stb = 1'b0;
    logic       sel_en = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // reference model: src and disable per word
    logic [2:0] m_stage_src [8];
    logic       m_stage_off [8];
    logic [2:0] m_live_src  [8];
    logic       m_live_off  [8];

    always #5 clk = ~clk;

    xbar_ctrl uut (
        .clk(clk), .rst_n(rst_n), .din(din), .dout(dout), .dout_en(dout_en),
        .in_sel(in_sel), .out_sel(out_sel), .off_req(off_req),
        .stage_stb(stage_stb), .commit_stb(commit_stb), .preset_stb(preset_stb),
        .sel_en(sel_en)
    );

    task automatic check_out(input string req);
        logic [7:0] e_d, e_en;
        for (int o = 0; o < 8; o++) begin
            e_en[o] = ~m_live_off[o];
            e_d[o]  = m_live_off[o] ? 1'b0 : din[m_live_src[o]];
        end
        n_checks++;
        if (dout !== e_d || dout_en !== e_en) begin
            n_fail++;
            $display("FAIL %s: dout=%h en=%h expected dout=%h en=%h (din=%h)",
                     req, dout, dout_en, e_d, e_en, din);
        end
    endtask

    task automatic check_pats(input string req);
        logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
        for (int p = 0; p < 4; p++) begin
            din = pats[p];
            #1;
            check_out(req);
        end
    endtask

    task automatic m_stage_wr(input logic [2:0] o, input logic [2:0] i, input logic off);
        m_stage_src[o] = i;
        m_stage_off[o] = off;
    endtask

    task automatic m_commit();
        for (int w = 0; w < 8; w++) begin
            m_live_src[w] = m_stage_src[w];
            m_live_off[w] = m_stage_off[w];
        end
    endtask

    task automatic m_preset(input logic off);
        for (int w = 0; w < 8; w++) begin
            m_stage_src[w] = 3'd0; m_stage_off[w] = off;
            m_live_src[w]  = 3'd0; m_live_off[w]  = off;
        end
    endtask

    // one-cycle strobes, driven at negedge, released at next negedge
    task automatic pulse(input logic s, input logic c, input logic p);
        @(negedge clk);
        stage_stb = s; commit_stb = c; preset_stb = p;
        @(negedge clk);
        stage_stb = 1'b0; commit_stb = 1'b0; preset_stb = 1'b0;
    endtask

    task automatic stage(input logic [2:0] o, input logic [2:0] i, input logic off);
        @(negedge clk);
        out_sel = o; in_sel = i; off_req = off;
        pulse(1'b1, 1'b0, 1'b0);
        m_stage_wr(o, i, off);
    endtask

    task automatic commit();
        pulse(1'b0, 1'b1, 1'b0);
        m_commit();
    endtask

    task automatic preset(input logic off);
        @(negedge clk);
        off_req = off;
        pulse(1'b0, 1'b0, 1'b1);
        m_preset(off);
    endtask

    task automatic t_reset();
        m_preset(1'b1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (dout !== 8'h00 || dout_en !== 8'h00) begin
            n_fail++;
            $display("FAIL R1: dout=%h en=%h expected dout=00 en=00", dout, dout_en);
        end
        check_pats("R1");
    endtask

    task automatic t_stage_then_commit();
        for (int o = 0; o < 8; o++) stage(3'(o), 3'(7 - o), (o == 3) ? 1'b1 : 1'b0);
        check_pats("R3 staging invisible before commit");
        commit();
        check_pats("R4 commit applies all");
        check_pats("R2 routing");
    endtask

    task automatic t_undisturbed();
        // keep outputs routed while staging and committing changes to output 5 only
        for (int k = 0; k < 3; k++) begin
            stage(3'd5, 3'(k), 1'b0);
            din = 8'h5A ^ 8'(k);
            #1;
            check_out("R5 during staging");
            commit();
            check_pats("R5 after commit");
        end
    endtask

    task automatic t_preset_modes();
        preset(1'b0);
        check_pats("R6 broadcast");
        commit();
        check_pats("R6 staging also preset");
        preset(1'b1);
        check_pats("R7 all off");
        commit();
        check_pats("R7 staging also preset");
    endtask

    task automatic t_select_gate();
        stage(3'd2, 3'd4, 1'b0);
        commit();
        @(negedge clk);
        sel_en = 1'b0;
        out_sel = 3'd2; in_sel = 3'd6; off_req = 1'b1;
        pulse(1'b1, 1'b0, 1'b0);
        pulse(1'b0, 1'b1, 1'b0);
        pulse(1'b0, 1'b0, 1'b1);
        check_pats("R8 strobes ignored");
        @(negedge clk);
        sel_en = 1'b1;
        commit();
        check_pats("R8 staging untouched");
    endtask

    task automatic t_held_level();
        @(negedge clk);
        out_sel = 3'd1; in_sel = 3'd3; off_req = 1'b0;
        stage_stb = 1'b1;
        @(negedge clk);
        in_sel = 3'd6; out_sel = 3'd0;
        @(negedge clk);
        in_sel = 3'd7; off_req = 1'b1;
        @(negedge clk);
        stage_stb = 1'b0;
        m_stage_wr(3'd1, 3'd3, 1'b0);
        off_req = 1'b0;
        commit();
        check_pats("R9 held strobe acts once");
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        out_sel = 3'd6; in_sel = 3'd2; off_req = 1'b0;
        pulse(1'b1, 1'b1, 1'b0);
        m_stage_wr(3'd6, 3'd2, 1'b0);
        m_commit();
        check_pats("R10 write forwarded into commit");
        @(negedge clk);
        out_sel = 3'd4; in_sel = 3'd5; off_req = 1'b1;
        pulse(1'b1, 1'b1, 1'b1);
        m_preset(1'b1);
        check_pats("R11 preset wins");
        @(negedge clk);
        off_req = 1'b0;
        commit();
        check_pats("R11 staging holds preset");
    endtask

    task automatic t_fanout();
        for (int o = 0; o < 8; o++) stage(3'(o), 3'd5, 1'b0);
        commit();
        for (int p = 0; p < 4; p++) begin
            din = (p[0]) ? 8'h20 : 8'hDF;
            #1;
            check_out("R12 fanout");
            n_checks++;
            if (dout !== {8{din[5]}}) begin
                n_fail++;
                $display("FAIL R12: dout=%h expected %h", dout, {8{din[5]}});
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_stage_then_commit();
        t_undisturbed();
        t_preset_modes();
        t_select_gate();
        t_held_level();
        t_same_cycle();
        t_fanout();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule